// File: doc/BRIEF.md
# Down-Counting Timer Channel

This block is one channel of a general-purpose timer. It holds a counter, a reload value and a small control register. On each cycle where the external prescaler tick is high and the channel is enabled, the counter steps down by one. The channel expires when a tick arrives while the counter is already zero, so the expiry comes on underflow and not on reaching zero. A programmed value N therefore gives N+1 ticks before expiry. On expiry the channel can raise a one-cycle interrupt pulse and a sticky pending flag. It then either reloads itself and keeps counting, or stops.

Bus decoding and the prescaler are outside the block. The surrounding logic gives one write strobe with data for each register. It reads the live count and the control readback straight from the outputs. Two control bits, chain and debug halt, are stored or accepted but have no effect on counting.

Top module: `tmr_chan`

## Requirements
- R1: After a synchronous active-low reset, the counter, reload and control registers are zero, the channel is disabled and `irq_o` is low.
- R2: Control bits are: bit 0 enable, bit 1 restart, bit 2 load, bit 3 interrupt enable, bit 4 pending, bit 5 chain, bit 6 debug halt. Readback returns bits 0, 1, 3 and 5 as last written, bit 4 as the pending flag, and zero in bits 2 and 6.
- R3: The counter decreases by exactly one on each cycle where `tick_i` is high, enable is set and no register write occurs. In every other cycle without a write, it holds its value.
- R4: Expiry happens on a qualifying tick while the counter is zero. After a value N is loaded, the first N ticks bring the counter to zero with no expiry, and tick N+1 expires.
- R5: On expiry with interrupt enable set, the pending flag sets and `irq_o` is high for the one cycle after the expiring edge. With interrupt enable clear, neither happens.
- R6: On expiry with restart set, the counter takes the reload value and enable stays set. With restart clear, the counter stays at zero and enable clears.
- R7: A control write with bit 4 set clears the pending flag. A control write with bit 4 clear leaves the pending flag unchanged.
- R8: A control write with bit 2 set copies the reload register into the counter. It uses the value held before any reload write in the same cycle, and it takes priority over a counter write in the same cycle.
- R9: A counter write without load sets the count directly, whether or not the channel is enabled, and counting continues from it when enabled.
- R10: A tick in a cycle that carries any register write is dropped, so the counter reflects only the write.
- R11: The chain and debug halt bits have no effect on counting or expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaler tick strobe |
| cnt_we_i | input | 1 | Counter register write strobe |
| cnt_wdata_i | input | WIDTH | Counter write data |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | WIDTH | Reload write data |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 7 | Control write data |
| count_o | output | WIDTH | Current counter value |
| ctl_rdata_o | output | 7 | Control register readback |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that each write strobe stands for exactly one clock cycle per access. They also assume that reset is held low for at least one edge before any strobe matters. The stimulus drives every strobe and the tick on the falling clock edge and releases them one cycle later, so each access is a single-cycle pulse. It sweeps loaded values from 0 to 12 across all four restart and interrupt-enable combinations. It puts idle cycles between ticks so that hold behaviour is exercised alongside counting.

// File: rtl/tmr_chan_pkg.sv
// Package: shared control-bit positions and the stored control state of
// the timer channel. Assumes a 7-bit control word.
package tmr_chan_pkg;
    localparam int CTL_W      = 7;
    localparam int CB_EN      = 0;
    localparam int CB_RESTART = 1;
    localparam int CB_LOAD    = 2;
    localparam int CB_IRQEN   = 3;
    localparam int CB_PEND    = 4;
    localparam int CB_CHAIN   = 5;
    localparam int CB_HALT    = 6;

    typedef struct packed {
        logic chain;
        logic pend;
        logic irq_en;
        logic restart;
        logic en;
    } ctl_state_t;
endpackage

// File: rtl/tmr_reload_reg.sv
// Module: holds the reload value of the channel.
// Assumes one write strobe; resets to zero.
module tmr_reload_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Capture a new reload value on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    p_reload_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wdata));
endmodule

// File: rtl/tmr_ctl_reg.sv
// Module: control state of the channel, with the sticky pending flag and
// the interrupt pulse. Assumes that expire is never high in a cycle with
// a control write (the top drops ticks on any write).
module tmr_ctl_reg
    import tmr_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  ctl_state_t       wr,
    input  logic             expire,
    output ctl_state_t       st,
    output logic             irq_o
);
    // Update control fields on write; apply expiry effects otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= expire & st.irq_en;
            if (we) begin
                st.en      <= wr.en;
                st.restart <= wr.restart;
                st.irq_en  <= wr.irq_en;
                st.chain   <= wr.chain;
                st.pend    <= wr.pend ? 1'b0 : st.pend;
            end else if (expire) begin
                if (st.irq_en)   st.pend <= 1'b1;
                if (!st.restart) st.en   <= 1'b0;
            end
        end
    end

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr.pend) |=> !st.pend);
    p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr.pend) |=> st.pend == $past(st.pend));
    p_stop_on_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st.restart && !we) |=> !st.en);
    p_irq_has_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> st.pend);
endmodule

// File: rtl/tmr_down_cnt.sv
// Module: the down counter. Load beats a counter write, which beats
// expiry and decrement. Expiry is a qualified tick while the count is
// zero. Assumes tick_ok is already gated by enable and by write activity.
module tmr_down_cnt #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ok,
    input  logic             load,
    input  logic             cnt_we,
    input  logic [WIDTH-1:0] cnt_wdata,
    input  logic [WIDTH-1:0] reload_q,
    input  logic             restart,
    output logic [WIDTH-1:0] count,
    output logic             expire
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Underflow detection on a qualified tick.
    always_comb expire = tick_ok && (count == '0);

    // Counter update with load > write > expiry > decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (load)      count <= reload_q;
        else if (cnt_we)    count <= cnt_wdata;
        else if (expire)    count <= restart ? reload_q : count;
        else if (tick_ok)   count <= count - ONE;
    end

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && count != '0 && !load && !cnt_we) |=> count == $past(count) - ONE);
    p_restart_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && restart && !load && !cnt_we) |=> count == $past(reload_q));
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(reload_q));
endmodule

// File: rtl/tmr_chan.sv
// Module: top of the down-counting timer channel. Qualifies the tick,
// splits the control write into fields and assembles the readback.
// Assumes single-cycle write strobes from outside decode logic.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_we_i,
    input  logic [WIDTH-1:0] cnt_wdata_i,
    input  logic             rld_we_i,
    input  logic [WIDTH-1:0] rld_wdata_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic [CTL_W-1:0] ctl_rdata_o,
    output logic             irq_o
);
    ctl_state_t       st;
    ctl_state_t       wr;
    logic [WIDTH-1:0] reload_q;
    logic             any_we;
    logic             tick_ok;
    logic             load;
    logic             expire;
    logic             unused_halt_bit;

    // Split control write data into stored fields.
    always_comb begin
        wr.en      = ctl_wdata_i[CB_EN];
        wr.restart = ctl_wdata_i[CB_RESTART];
        wr.irq_en  = ctl_wdata_i[CB_IRQEN];
        wr.pend    = ctl_wdata_i[CB_PEND];
        wr.chain   = ctl_wdata_i[CB_CHAIN];
    end
    assign unused_halt_bit = ctl_wdata_i[CB_HALT];

    // Tick qualification: enabled and no register access this cycle.
    always_comb begin
        any_we  = cnt_we_i | rld_we_i | ctl_we_i;
        tick_ok = tick_i & st.en & ~any_we;
        load    = ctl_we_i & ctl_wdata_i[CB_LOAD];
    end

    // Readback: load and debug halt read as zero.
    always_comb begin
        ctl_rdata_o              = '0;
        ctl_rdata_o[CB_EN]       = st.en;
        ctl_rdata_o[CB_RESTART]  = st.restart;
        ctl_rdata_o[CB_IRQEN]    = st.irq_en;
        ctl_rdata_o[CB_PEND]     = st.pend;
        ctl_rdata_o[CB_CHAIN]    = st.chain;
    end

    tmr_reload_reg #(.WIDTH(WIDTH)) u_rld (
        .clk(clk), .rst_n(rst_n), .we(rld_we_i), .wdata(rld_wdata_i), .q(reload_q)
    );

    tmr_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we_i), .wr(wr),
        .expire(expire), .st(st), .irq_o(irq_o)
    );

    tmr_down_cnt #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_ok(tick_ok), .load(load),
        .cnt_we(cnt_we_i), .cnt_wdata(cnt_wdata_i), .reload_q(reload_q),
        .restart(st.restart), .count(count_o), .expire(expire)
    );

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.en && !cnt_we_i && !ctl_we_i) |=> $stable(count_o));
    p_write_drops_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_we_i && !cnt_we_i && !ctl_we_i) |=> $stable(count_o));
endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         cnt_we_i = 1'b0;
    logic [W-1:0] cnt_wdata_i = '0;
    logic         rld_we_i = 1'b0;
    logic [W-1:0] rld_wdata_i = '0;
    logic         ctl_we_i = 1'b0;
    logic [6:0]   ctl_wdata_i = '0;
    logic [W-1:0] count_o;
    logic [6:0]   ctl_rdata_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tmr_chan #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
        .rld_we_i(rld_we_i), .rld_wdata_i(rld_wdata_i),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .count_o(count_o), .ctl_rdata_o(ctl_rdata_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // Control encodings (R2): en=bit0 restart=bit1 load=bit2 ie=bit3 pend=bit4 chain=bit5 halt=bit6
    localparam logic [6:0] EN = 7'h01, RS = 7'h02, LD = 7'h04, IE = 7'h08,
                           PD = 7'h10, CH = 7'h20, HL = 7'h40;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied on the falling edge and released after.
    task automatic cyc(input logic tk, input logic cw, input logic [W-1:0] cd,
                       input logic rw, input logic [W-1:0] rd,
                       input logic kw, input logic [6:0] kd);
        tick_i = tk; cnt_we_i = cw; cnt_wdata_i = cd;
        rld_we_i = rw; rld_wdata_i = rd; ctl_we_i = kw; ctl_wdata_i = kd;
        @(negedge clk);
        tick_i = 0; cnt_we_i = 0; rld_we_i = 0; ctl_we_i = 0;
    endtask

    task automatic tick();          cyc(1, 0, '0, 0, '0, 0, '0); endtask
    task automatic idle();          cyc(0, 0, '0, 0, '0, 0, '0); endtask
    task automatic wctl(input logic [6:0] v); cyc(0, 0, '0, 0, '0, 1, v); endtask
    task automatic wcnt(input logic [W-1:0] v); cyc(0, 1, v, 0, '0, 0, '0); endtask
    task automatic wrld(input logic [W-1:0] v); cyc(0, 0, '0, 1, v, 0, '0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 count", count_o, 0);
        chk("R1 ctl", {25'd0, ctl_rdata_o}, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        // R3: ticks while disabled do nothing
        tick(); tick();
        chk("R3 disabled hold", count_o, 0);
        chk("R3 no irq disabled", {31'd0, irq_o}, 0);

        // R4 R5 R6: sweep of loaded value and mode
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n <= 12; n++) begin
                logic r, ie;
                logic [6:0] base;
                r = m[0]; ie = m[1];
                base = EN | (r ? RS : 7'h0) | (ie ? IE : 7'h0);
                wrld(W'(n));
                wctl(base | LD | PD);
                chk("R8 load copies reload", count_o, W'(n));
                chk("R2 readback", {25'd0, ctl_rdata_o}, {25'd0, base});
                for (int k = 1; k <= n; k++) begin
                    tick();
                    chk("R3 decrement", count_o, W'(n - k));
                    chk("R4 no early expiry", {31'd0, irq_o}, 0);
                    if (k % 3 == 0) begin
                        idle();
                        chk("R3 hold without tick", count_o, W'(n - k));
                    end
                end
                tick();
                chk("R5 irq on underflow", {31'd0, irq_o}, {31'd0, ie});
                chk("R5 pending", {31'd0, ctl_rdata_o[4]}, {31'd0, ie});
                chk("R6 count after expiry", count_o, r ? W'(n) : 0);
                chk("R6 enable after expiry", {31'd0, ctl_rdata_o[0]}, {31'd0, r});
                idle();
                chk("R5 single-cycle pulse", {31'd0, irq_o}, 0);
                if (!r) begin
                    tick();
                    chk("R6 stopped", count_o, 0);
                    chk("R6 no further irq", {31'd0, irq_o}, 0);
                end
                wctl(PD);
            end
        end

        // R7: pending clear semantics
        wrld(W'(1));
        wctl(EN | IE | LD | PD);
        tick(); tick();
        chk("R7 pending set", {31'd0, ctl_rdata_o[4]}, 1);
        wctl(IE);
        chk("R7 write 0 keeps pending", {31'd0, ctl_rdata_o[4]}, 1);
        wctl(IE | PD);
        chk("R7 write 1 clears pending", {31'd0, ctl_rdata_o[4]}, 0);

        // R8: load priority over counter write, old reload value
        wrld(W'(100));
        cyc(1, 1, W'(5), 1, W'(200), 1, LD);
        chk("R8 load beats write", count_o, W'(100));
        chk("R2 load reads zero", {31'd0, ctl_rdata_o[2]}, 0);
        wctl(LD);
        chk("R8 load uses latest reload", count_o, W'(200));

        // R9: direct counter write
        wctl(7'h0);
        wcnt(W'(7));
        chk("R9 write while disabled", count_o, W'(7));
        wctl(EN);
        tick();
        chk("R9 counts from written value", count_o, W'(6));
        wcnt(W'(3));
        chk("R9 write while enabled", count_o, W'(3));

        // R10: write in same cycle drops tick
        cyc(1, 0, '0, 1, W'(9), 0, '0);
        chk("R10 reload write drops tick", count_o, W'(3));
        cyc(1, 0, '0, 0, '0, 1, EN);
        chk("R10 control write drops tick", count_o, W'(3));
        cyc(1, 1, W'(50), 0, '0, 0, '0);
        chk("R10 counter write drops tick", count_o, W'(50));

        // R11: chain and halt have no effect
        wctl(EN | CH | HL);
        chk("R2 chain reads back, halt reads zero", {25'd0, ctl_rdata_o}, {25'd0, EN | CH});
        tick();
        chk("R11 counts with chain and halt", count_o, W'(49));
        wcnt(W'(0));
        tick();
        chk("R11 expiry stops channel", {31'd0, ctl_rdata_o[0]}, 0);

        // R1: reset mid-operation
        wrld(W'(4)); wctl(EN | RS | LD);
        rst_n = 1'b0; idle(); rst_n = 1'b1;
        chk("R1 reset count", count_o, 0);
        chk("R1 reset ctl", {25'd0, ctl_rdata_o}, 0);
        wctl(LD);
        chk("R1 reload reset", count_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule